// File: doc/BRIEF.md
# Descriptor Flag-Update Bus Sequencer

This block loads an 8-byte segment descriptor over a 32-bit memory bus and, when needed, sets one flag bit in it with an atomic read-modify-write. The flag is either the Accessed bit of a code or data segment descriptor or the Busy bit of a task-state descriptor. A single `start` strobe with a linear byte address and a flag selector launches one operation. The block first reads the whole descriptor with unlocked cycles. If the chosen flag is already set, it finishes at once. If not, it takes the bus lock, reads the upper descriptor dword again, ORs the flag into that fresh copy, and writes it back.

The descriptor address does not have to be dword-aligned. An unaligned address makes every dword access two bus pieces, split at the dword boundary. The bus is a request/ready channel. A transfer happens on the clock edge where `bus_req` and `bus_rdy` are both high. While `bus_rdy` is low, the block holds the whole request unchanged, so the memory side can insert any number of wait states. `start`, `busy`, `done` and `desc` are plain control and status pins. A `start` pulse is taken only when `busy` is low.

Top module: `desc_flag_seq`

## Requirements
- R1: With `desc_addr[1:0]==0`, the descriptor is read with exactly two unlocked reads (`bus_we=0`, `bus_lock=0`, `bus_be=4'b1111`), first at the descriptor address and then at address+4.
- R2: In the aligned case with the flag clear, the unlocked reads are followed by exactly one locked read and then one locked write, both at descriptor address+4 with `bus_be=4'b1111`.
- R3: With offset o=`desc_addr[1:0]`≠0 and base B=`desc_addr` with the low two bits cleared, the descriptor is read with four unlocked reads in this order: B, B+4, B+4, B+8. The first piece of each half uses `bus_be = 4'b1111<<o`, which selects lanes o..3. The second piece uses the complement, which selects lanes 0..o-1.
- R4: In the unaligned case with the flag clear, the unlocked reads are followed by two locked reads at B+4 and B+8, then two locked writes at B+4 and B+8, with the same byte-enable rule as R3.
- R5: `flag_sel=0` selects the Accessed flag, bit 8 of the upper descriptor dword (bit 0 of descriptor byte 5). `flag_sel=1` selects the Busy flag, bit 9 of that dword (bit 1 of byte 5). Both flags use the same cycle sequence.
- R6: If the selected flag reads as set in the unlocked copy, no locked cycle is issued and `done` follows the last unlocked read.
- R7: `bus_lock` is high from the first locked read through the last locked write, with no gap. It is low during unlocked reads and in the cycle after the final write completes. Every write is locked.
- R8: The written data equals the value returned by the locked read with only the selected flag ORed in. Memory bytes changed by another agent between the unlocked and the locked phase are preserved.
- R9: While `bus_req` is high and `bus_rdy` is low, `bus_addr`, `bus_be`, `bus_we`, `bus_lock`, `bus_wdata` and `bus_req` stay unchanged into the next cycle.
- R10: `done` is a one-cycle pulse. While it is high, `desc` holds the descriptor, and its upper dword equals the written value when an update took place. `busy` is high from the cycle after an accepted `start` through the `done` cycle.
- R11: A `start` pulse while `busy` is high is ignored. The running operation completes unchanged and no further bus request follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch strobe, taken when idle |
| desc_addr | input | ADDR_W | Linear byte address of the descriptor |
| flag_sel | input | 1 | 0 = Accessed flag, 1 = Busy flag |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| desc | output | 2*DATA_W | Assembled descriptor, low dword in the low bits |
| bus_req | output | 1 | Bus request valid |
| bus_rdy | input | 1 | Bus ready; transfer when high with bus_req |
| bus_addr | output | ADDR_W | Dword-aligned bus address |
| bus_be | output | DATA_W/8 | Byte lane enables |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_lock | output | 1 | Locked-cycle indicator |
| bus_wdata | output | DATA_W | Write data on byte lanes |
| bus_rdata | input | DATA_W | Read data, valid when bus_rdy is high |

## Verification
The properties assume that the memory side drives `bus_rdy` only as a response to a pending request. They also assume that `start` is not expected to have any effect while an operation runs. The bench's responder therefore answers only when it sees `bus_req` high and inserts wait states at random. It presents read data in the same cycle as `bus_rdy`, and it sends extra `start` pulses mid-operation only to check that they are ignored. Descriptor placements stay inside the responder's small memory image, so every piece address maps to a real dword there. Random byte content keeps both flag bits and their neighbours in every state.

// File: rtl/desc_flag_pkg.sv
package desc_flag_pkg;

  // Sequencer phases: unlocked descriptor fetch, locked re-read, locked write-back
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_URD  = 3'd1,
    ST_LRD  = 3'd2,
    ST_LWR  = 3'd3,
    ST_DONE = 3'd4
  } seq_state_t;

endpackage

// File: rtl/desc_piece_addr.sv
// Forms the dword bus address and lane enables of one bus piece.
// half selects the descriptor dword, piece selects the part of a split access.
module desc_piece_addr #(
  parameter int ADDR_W = 32,
  parameter int LANES  = 4
) (
  input  logic [ADDR_W-$clog2(LANES)-1:0] base_w,
  input  logic [$clog2(LANES)-1:0]        off,
  input  logic                            half,
  input  logic                            piece,
  output logic [ADDR_W-1:0]               addr,
  output logic [LANES-1:0]                be
);
  localparam int OFF_W = $clog2(LANES);
  localparam int IDX_W = ADDR_W - OFF_W;
  localparam logic [LANES-1:0] ALL_LANES = '1;

  logic [IDX_W-1:0] idx;
  logic [LANES-1:0] upper_mask;

  assign idx        = base_w + IDX_W'(half) + IDX_W'(piece);
  assign addr       = {idx, {OFF_W{1'b0}}};
  assign upper_mask = ALL_LANES << off;
  assign be         = piece ? ~upper_mask : upper_mask;
endmodule

// File: rtl/desc_lane_merge.sv
// Rebuilds one descriptor dword from the two bus pieces of a split read.
// With a zero offset the result is the first piece unchanged.
module desc_lane_merge #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]            first,
  input  logic [DATA_W-1:0]            second,
  input  logic [$clog2(DATA_W/8)-1:0]  off,
  output logic [DATA_W-1:0]            dword
);
  logic [2*DATA_W-1:0] joined;
  logic [2*DATA_W-1:0] shifted;

  assign joined  = {second, first};
  assign shifted = joined >> {off, 3'b000};
  assign dword   = shifted[DATA_W-1:0];
endmodule

// File: rtl/desc_lane_split.sv
// Places one descriptor dword onto the lanes of the two write pieces.
module desc_lane_split #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]            dword,
  input  logic [$clog2(DATA_W/8)-1:0]  off,
  output logic [DATA_W-1:0]            piece_a,
  output logic [DATA_W-1:0]            piece_b
);
  logic [2*DATA_W-1:0] spread;

  assign spread  = {{DATA_W{1'b0}}, dword} << {off, 3'b000};
  assign piece_a = spread[DATA_W-1:0];
  assign piece_b = spread[2*DATA_W-1:DATA_W];
endmodule

// File: rtl/desc_flag_seq.sv
// Descriptor fetch and atomic flag update over a request/ready dword bus.
module desc_flag_seq
  import desc_flag_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int ACC_BIT  = 8,
  parameter int BUSY_BIT = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [ADDR_W-1:0]     desc_addr,
  input  logic                  flag_sel,
  output logic                  busy,
  output logic                  done,
  output logic [2*DATA_W-1:0]   desc,
  output logic                  bus_req,
  input  logic                  bus_rdy,
  output logic [ADDR_W-1:0]     bus_addr,
  output logic [DATA_W/8-1:0]   bus_be,
  output logic                  bus_we,
  output logic                  bus_lock,
  output logic [DATA_W-1:0]     bus_wdata,
  input  logic [DATA_W-1:0]     bus_rdata
);
  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);
  localparam int IDX_W = ADDR_W - OFF_W;

  seq_state_t        state_q;
  logic [1:0]        cnt_q;
  logic [IDX_W-1:0]  base_q;
  logic [OFF_W-1:0]  off_q;
  logic              sel_q;
  logic [DATA_W-1:0] tmp_q;
  logic [DATA_W-1:0] lo_q;
  logic [DATA_W-1:0] hi_q;

  logic              mis;
  logic              half_c;
  logic              piece_c;
  logic              last_c;
  logic              half_end;
  logic              xfer;
  logic [DATA_W-1:0] merge_first;
  logic [DATA_W-1:0] merged;
  logic [DATA_W-1:0] flag_mask;
  logic [DATA_W-1:0] wr_a;
  logic [DATA_W-1:0] wr_b;

  assign mis = |off_q;

  // Which dword and which split piece the current bus cycle carries
  always_comb begin
    half_c  = 1'b1;
    piece_c = 1'b0;
    last_c  = 1'b0;
    case (state_q)
      ST_URD: begin
        half_c  = mis ? cnt_q[1] : cnt_q[0];
        piece_c = mis & cnt_q[0];
        last_c  = mis ? (cnt_q == 2'd3) : (cnt_q == 2'd1);
      end
      ST_LRD, ST_LWR: begin
        piece_c = mis & cnt_q[0];
        last_c  = mis ? cnt_q[0] : 1'b1;
      end
      default: ;
    endcase
  end

  assign bus_req  = (state_q == ST_URD) || (state_q == ST_LRD) || (state_q == ST_LWR);
  assign bus_we   = (state_q == ST_LWR);
  assign bus_lock = (state_q == ST_LRD) || (state_q == ST_LWR);
  assign busy     = (state_q != ST_IDLE);
  assign done     = (state_q == ST_DONE);
  assign desc     = {hi_q, lo_q};

  assign xfer      = bus_req & bus_rdy;
  assign half_end  = ~mis | piece_c;
  assign flag_mask = sel_q ? (DATA_W'(1) << BUSY_BIT) : (DATA_W'(1) << ACC_BIT);

  desc_piece_addr #(
    .ADDR_W (ADDR_W),
    .LANES  (LANES)
  ) u_addr (
    .base_w (base_q),
    .off    (off_q),
    .half   (half_c),
    .piece  (piece_c),
    .addr   (bus_addr),
    .be     (bus_be)
  );

  assign merge_first = piece_c ? tmp_q : bus_rdata;

  desc_lane_merge #(
    .DATA_W (DATA_W)
  ) u_merge (
    .first  (merge_first),
    .second (bus_rdata),
    .off    (off_q),
    .dword  (merged)
  );

  desc_lane_split #(
    .DATA_W (DATA_W)
  ) u_split (
    .dword   (hi_q),
    .off     (off_q),
    .piece_a (wr_a),
    .piece_b (wr_b)
  );

  assign bus_wdata = piece_c ? wr_b : wr_a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      base_q  <= '0;
      off_q   <= '0;
      sel_q   <= 1'b0;
      tmp_q   <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            base_q  <= desc_addr[ADDR_W-1:OFF_W];
            off_q   <= desc_addr[OFF_W-1:0];
            sel_q   <= flag_sel;
            cnt_q   <= '0;
            state_q <= ST_URD;
          end
        end
        ST_URD: begin
          if (xfer) begin
            if (mis && !piece_c) tmp_q <= bus_rdata;
            if (half_end) begin
              if (half_c) hi_q <= merged;
              else        lo_q <= merged;
            end
            if (last_c) begin
              cnt_q   <= '0;
              state_q <= (|(merged & flag_mask)) ? ST_DONE : ST_LRD;
            end else begin
              cnt_q <= cnt_q + 2'd1;
            end
          end
        end
        ST_LRD: begin
          if (xfer) begin
            if (mis && !piece_c) tmp_q <= bus_rdata;
            if (half_end) hi_q <= merged | flag_mask;
            if (last_c) begin
              cnt_q   <= '0;
              state_q <= ST_LWR;
            end else begin
              cnt_q <= cnt_q + 2'd1;
            end
          end
        end
        ST_LWR: begin
          if (xfer) begin
            if (last_c) begin
              cnt_q   <= '0;
              state_q <= ST_DONE;
            end else begin
              cnt_q <= cnt_q + 2'd1;
            end
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/desc_flag_seq_chk.sv
// Port-level properties of the descriptor flag sequencer.
module desc_flag_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic                busy,
  input logic                done,
  input logic                bus_req,
  input logic                bus_rdy,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [DATA_W/8-1:0] bus_be,
  input logic                bus_we,
  input logic                bus_lock,
  input logic [DATA_W-1:0]   bus_wdata
);
  assert_hold_until_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_rdy) |=> (bus_req && $stable(bus_addr) && $stable(bus_be) &&
                               $stable(bus_we) && $stable(bus_lock) && $stable(bus_wdata)));

  assert_write_is_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we) |-> bus_lock);

  assert_lock_released_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_lock) |-> $past(bus_req && bus_rdy && bus_we));

  assert_lock_no_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_lock && !(bus_req && bus_rdy && bus_we)) |=> bus_lock);

  assert_locked_phase_opens_with_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_lock) |-> !bus_we);

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_quiet_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!bus_lock && !bus_req && busy));

  assert_req_only_when_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> busy);

  assert_start_ignored_while_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && start) |=> busy);

  assert_lanes_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (bus_be != '0));
endmodule

bind desc_flag_seq desc_flag_seq_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .bus_req   (bus_req),
  .bus_rdy   (bus_rdy),
  .bus_addr  (bus_addr),
  .bus_be    (bus_be),
  .bus_we    (bus_we),
  .bus_lock  (bus_lock),
  .bus_wdata (bus_wdata)
);

// File: tb/desc_flag_seq_test.sv
`timescale 1ns/1ps
module desc_flag_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] desc_addr = '0;
  logic        flag_sel = 1'b0;
  logic        busy, done;
  logic [63:0] desc;
  logic        bus_req;
  logic        bus_rdy = 1'b0;
  logic [31:0] bus_addr;
  logic [3:0]  bus_be;
  logic        bus_we, bus_lock;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata = '0;

  always #4 clk = ~clk;

  desc_flag_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .desc_addr(desc_addr), .flag_sel(flag_sel),
    .busy(busy), .done(done), .desc(desc), .bus_req(bus_req), .bus_rdy(bus_rdy),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_we(bus_we), .bus_lock(bus_lock),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  int n_checks = 0;
  int n_fail   = 0;

  logic [7:0] mem [64];
  logic [7:0] pre [64];

  // State shared with the responder
  int cur_base, cur_off, cur_lw_exp, rdy_pct;
  bit cur_mis, cur_mutate;
  int ur, lr, lw, seq_err, lock_err;
  bit chk_release, hold_valid;
  logic [31:0] h_addr;
  logic [3:0]  h_be;
  logic        h_we;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_piece_addr(int base, int h, int p);
    return 32'((base + h + p) * 4);
  endfunction

  function automatic logic [3:0] exp_piece_be(int off, int p);
    logic [3:0] m;
    m = 4'hF << off;
    return p != 0 ? ~m : m;
  endfunction

  // Memory-side responder with random wait states
  initial begin
    forever begin
      @(negedge clk);
      if (chk_release) begin
        if (bus_lock) lock_err++;
        chk_release = 1'b0;
      end
      if (hold_valid) begin
        if (!bus_req || bus_addr != h_addr || bus_be != h_be || bus_we != h_we) seq_err++;
        hold_valid = 1'b0;
      end
      if (lr > 0 && lw < cur_lw_exp && !bus_lock) lock_err++;
      bus_rdy = 1'b0;
      if (bus_req) begin
        if (int'($urandom % 100) >= rdy_pct) begin
          hold_valid = 1'b1;
          h_addr = bus_addr; h_be = bus_be; h_we = bus_we;
        end else begin
          int k, h, p, a;
          bus_rdy = 1'b1;
          if (!bus_we && !bus_lock) begin
            k = ur; h = cur_mis ? k / 2 : k; p = cur_mis ? k % 2 : 0;
            if (lr + lw > 0) seq_err++;
            ur++;
          end else if (!bus_we) begin
            if (lw > 0) seq_err++;
            if (lr == 0 && cur_mutate) mem[cur_base*4 + cur_off + 7] ^= 8'h5A;
            k = lr; h = 1; p = k;
            lr++;
          end else begin
            if (!bus_lock) lock_err++;
            k = lw; h = 1; p = k;
            lw++;
            if (lw == cur_lw_exp) chk_release = 1'b1;
          end
          if (bus_addr != exp_piece_addr(cur_base, h, p) || bus_be != exp_piece_be(cur_off, p))
            seq_err++;
          a = int'(bus_addr[5:0]);
          if (!bus_we) begin
            bus_rdata = {mem[a+3], mem[a+2], mem[a+1], mem[a]};
          end else begin
            for (int i = 0; i < 4; i++)
              if (bus_be[i]) mem[a+i] = bus_wdata[8*i +: 8];
          end
        end
      end
    end
  end

  task automatic run_op(input int base, input int off, input bit sel, input bit pre_set,
                        input bit mutate, input int pct, input bit extra_start);
    int d, i, fails_bytes;
    bit locked, seen;
    logic [7:0] expm [64];
    logic [63:0] exp_desc;
    string tu, tl;
    d = base * 4 + off;
    for (int j = 0; j < 64; j++) mem[j] = 8'($urandom);
    if (pre_set) mem[d+5] = mem[d+5] | (8'h1 << sel);
    else         mem[d+5] = mem[d+5] & ~(8'h1 << sel);
    for (int j = 0; j < 64; j++) pre[j] = mem[j];
    locked = !pre_set;
    cur_base = base; cur_off = off; cur_mis = (off != 0); cur_mutate = mutate;
    cur_lw_exp = locked ? (cur_mis ? 2 : 1) : 0;
    rdy_pct = pct;
    ur = 0; lr = 0; lw = 0; seq_err = 0; lock_err = 0;
    for (int j = 0; j < 64; j++) expm[j] = pre[j];
    if (locked) begin
      if (mutate) expm[d+7] ^= 8'h5A;
      expm[d+5] = expm[d+5] | (8'h1 << sel);
    end
    for (int j = 7; j >= 0; j--) exp_desc = {exp_desc[55:0], expm[d+j]};

    @(negedge clk);
    start = 1'b1; desc_addr = 32'(d); flag_sel = sel;
    @(negedge clk);
    start = 1'b0;
    i = 0; seen = 1'b0;
    while (!seen && i < 200) begin
      @(negedge clk);
      i++;
      if (extra_start && i == 1) begin
        start = 1'b1; desc_addr = 32'h24; flag_sel = ~sel;
      end
      if (i == 2) start = 1'b0;
      if (done) seen = 1'b1;
    end
    start = 1'b0;
    chk(seen, "R10", "done pulse seen", longint'(seen), 1);
    chk(desc == exp_desc, "R10", "descriptor at done", desc, exp_desc);
    @(negedge clk);
    chk(!done && !busy, "R10", "done single cycle then idle", {done, busy}, 0);
    tu = cur_mis ? "R3" : "R1";
    tl = !locked ? "R6" : (cur_mis ? "R4" : "R2");
    chk(ur == (cur_mis ? 4 : 2), tu, "unlocked read count", ur, cur_mis ? 4 : 2);
    chk(lr == cur_lw_exp, tl, "locked read count", lr, cur_lw_exp);
    chk(lw == cur_lw_exp, tl, "locked write count", lw, cur_lw_exp);
    chk(seq_err == 0, tu, "piece order, address, lanes and R9 hold", seq_err, 0);
    chk(lock_err == 0, "R7", "lock window", lock_err, 0);
    fails_bytes = 0;
    for (int j = 0; j < 64; j++) if (mem[j] != expm[j]) fails_bytes++;
    chk(fails_bytes == 0, "R8", "memory image after update", fails_bytes, 0);
    chk(mem[d+5] == (pre[d+5] | (locked ? (8'h1 << sel) : 8'h0)), "R5",
        "selected flag byte", mem[d+5], pre[d+5] | (locked ? (8'h1 << sel) : 8'h0));
    if (extra_start) begin
      repeat (3) begin
        @(negedge clk);
        chk(!bus_req && !busy, "R11", "no request after ignored start", {bus_req, busy}, 0);
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd7771));
    chk_release = 1'b0; hold_valid = 1'b0; rdy_pct = 100; cur_lw_exp = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!bus_req && !bus_lock && !done && !busy, "R10", "reset outputs quiet",
        {bus_req, bus_lock, done, busy}, 0);
    chk(desc == 64'h0, "R10", "reset descriptor", desc, 0);

    // Directed corner cases
    run_op(0, 0, 1'b0, 1'b0, 1'b1, 100, 1'b0);  // aligned, Accessed, R1 R2 R8
    run_op(2, 0, 1'b1, 1'b0, 1'b0, 100, 1'b0);  // aligned, Busy, R5
    run_op(3, 0, 1'b0, 1'b1, 1'b0, 100, 1'b0);  // aligned, already set, R6
    run_op(4, 1, 1'b0, 1'b0, 1'b1, 100, 1'b0);  // offset 1, R3 R4
    run_op(5, 3, 1'b1, 1'b0, 1'b1, 60, 1'b0);   // offset 3, flag in second piece, R9
    run_op(6, 2, 1'b0, 1'b1, 1'b0, 70, 1'b0);   // unaligned, already set, R6
    run_op(7, 1, 1'b1, 1'b0, 1'b0, 100, 1'b1);  // start while busy, R11
    run_op(1, 0, 1'b0, 1'b0, 1'b0, 100, 1'b1);  // aligned, start while busy, R11

    // Constrained random
    for (int n = 0; n < 150; n++) begin
      run_op(int'($urandom % 13), int'($urandom % 4), 1'($urandom), ($urandom % 4) == 0,
             1'($urandom), 40 + int'($urandom % 61), ($urandom % 8) == 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule